// File: doc/BRIEF.md
# Temperature Sensor Sampling Sequencer

The block sequences conversions for one on-die temperature sensing front end that can be pointed at an internal sensor or at one of several external sensors. Software configures it through two control words: the first holds the run bits (start, enable, reset), the source selection (mode and external channel), an oversampling rate that sets the sample period, and an averaging bypass. The second holds an averaging exponent N. The front end itself is replaced by a sample input: the block pulses `smp_take` on each edge where it captures `smp_data`, and drives `sel_ext`/`sel_chan` to tell the front end which sensor to present.

Raw samples are 10-bit two's-complement values. The block sums 2^N of them and publishes their mean, rounded toward minus infinity, in a status word with a valid flag. Any change of sensor source drops the valid flag. The flag comes back only after a complete averaged conversion on the new source, so software must poll it after switching. Stopping the sequencer also drops the flag. A restart discards any partially summed samples.

Top module: `tsense_seq`

## Requirements
- R1: `smp_take` pulses only while control-0 bit 0 (start) is 1, bit 2 (enable) is 1 and bit 1 (sensor reset) is 0. With any other combination no sample is taken.
- R2: When control-0 bits 31:30 equal 2 the external sensor is selected: `sel_ext`=1 and `sel_chan` equals control-0 bits 16:13. Any other mode value selects the internal sensor: `sel_ext`=0 and `sel_chan`=0.
- R3: With OSR = control-0 bits 25:24, samples are taken every (OSR+1)*STEP_CYCLES clock cycles. The first sample comes that many cycles after the control write that restarted the sequence.
- R4: With control-0 bit 6 set, each sample is published as-is. Otherwise N = control-1 bits 2:0 and each published result is the floor of the mean of 2^N consecutive samples (arithmetic right shift of the signed sum).
- R5: The status word carries the result in bits 9:0 as two's complement and the valid flag in bit 16. All other bits read 0.
- R6: A control-0 write that changes the mode, or changes the channel while in external mode, clears the valid flag on the next cycle. The flag stays low until the last of 2^N samples on the new source has been taken, and rises on the cycle after it.
- R7: A control-0 write that leaves the run condition false clears the valid flag. When the run condition becomes true again, averaging starts from an empty sum, and samples taken before the stop are not counted.
- R8: A control-0 write that changes only the channel field while in internal mode leaves the valid flag and the sample sequence undisturbed.
- R9: After reset both control words, the status word and `smp_take` are 0.
- R10: `ctrl0_q` and `ctrl1_q` return the last full words written to control-0 and control-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl0_wr | input | 1 | Write strobe for control-0 |
| ctrl0_wdata | input | 32 | Control-0 write data |
| ctrl1_wr | input | 1 | Write strobe for control-1 |
| ctrl1_wdata | input | 32 | Control-1 write data |
| smp_data | input | 10 | Raw signed sample from the sensing front end |
| ctrl0_q | output | 32 | Control-0 readback |
| ctrl1_q | output | 32 | Control-1 readback |
| status_q | output | 32 | Result in bits 9:0, valid flag in bit 16 |
| smp_take | output | 1 | High in the cycle whose closing edge captures `smp_data` |
| sel_ext | output | 1 | Front end set to an external sensor |
| sel_chan | output | 4 | External channel index presented to the front end |

## Verification
The hardest case to reach is a source switch or a stop that lands while the averaging window is only partly filled. The next published value must then be built only from samples taken after the switch, and the valid flag must stay low across the whole refill. The stimulus takes one sample, stops and restarts the sequencer, and then feeds a fresh window. It also switches the external channel right after a completed conversion and watches the flag on the edge of the last refill sample. Random sample values are mixed with a directed pair of negative samples whose mean is not an integer, which exposes the rounding direction.

// File: rtl/tsense_pkg.sv
package tsense_pkg;
  // Field positions inside the control-0 word
  localparam int C0_START    = 0;
  localparam int C0_SRST     = 1;
  localparam int C0_ENABLE   = 2;
  localparam int C0_NOAVG    = 6;
  localparam int C0_CHAN_LSB = 13;
  localparam int C0_OSR_LSB  = 24;
  localparam int C0_MODE_LSB = 30;
  // Status word
  localparam int ST_VALID    = 16;
  localparam int REG_W       = 32;
  // Default geometry
  localparam int SMP_W_D     = 10;
  localparam int EXP_W_D     = 3;
  localparam int CH_W_D      = 4;
  localparam int OSR_W_D     = 2;

  typedef enum logic [1:0] {
    SRC_INTERNAL = 2'd0,
    SRC_EXTERNAL = 2'd2
  } src_mode_e;
endpackage

// File: rtl/tsense_timer.sv
module tsense_timer #(
  parameter int STEP  = 4,
  parameter int OSR_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [OSR_W-1:0] osr,
  output logic             tick
);
  localparam int PMAX = STEP << OSR_W;
  localparam int CW   = $clog2(PMAX + 1);

  // sample period in cycles for a given oversampling code
  function automatic int unsigned period_of(input logic [OSR_W-1:0] code);
    return 32'(STEP) * (32'(code) + 32'd1);
  endfunction

  logic [CW-1:0] cnt_q;
  int unsigned   per;

  always_comb begin
    per  = period_of(osr);
    tick = run && (32'(cnt_q) == per - 32'd1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (clr || !run || tick) cnt_q <= '0;
    else                       cnt_q <= cnt_q + CW'(1);
  end

  // R3: the period counter never passes the programmed period
  p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (32'(cnt_q) < per));
endmodule

// File: rtl/tsense_accum.sv
module tsense_accum #(
  parameter int SMP_W = 10,
  parameter int EXP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic [SMP_W-1:0] smp,
  input  logic [EXP_W-1:0] n,
  output logic             done,
  output logic [SMP_W-1:0] result
);
  localparam int CNT_W = (1 << EXP_W) - 1;
  localparam int ACC_W = SMP_W + CNT_W;

  // mean of 2^sh samples, rounded toward minus infinity
  function automatic logic [SMP_W-1:0] mean_of(input logic signed [ACC_W-1:0] s,
                                               input logic [EXP_W-1:0] sh);
    logic signed [ACC_W-1:0] q;
    q = s >>> sh;
    return q[SMP_W-1:0];
  endfunction

  logic signed [ACC_W-1:0] acc_q, sum;
  logic [CNT_W-1:0]        cnt_q, last_idx;

  always_comb begin
    sum      = acc_q + $signed({{CNT_W{smp[SMP_W-1]}}, smp});
    last_idx = {CNT_W{1'b1}} >> (CNT_W - int'(n));
    done     = tick && (cnt_q == last_idx);
    result   = mean_of(sum, n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (clr) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (tick) begin
      if (done) begin
        acc_q <= '0;
        cnt_q <= '0;
      end else begin
        acc_q <= sum;
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  // R4: the sample index never runs past the window length
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last_idx);
endmodule

// File: rtl/tsense_seq.sv
module tsense_seq
  import tsense_pkg::*;
#(
  parameter int SMP_W       = SMP_W_D,
  parameter int EXP_W       = EXP_W_D,
  parameter int CH_W        = CH_W_D,
  parameter int OSR_W       = OSR_W_D,
  parameter int STEP_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl0_wr,
  input  logic [31:0]      ctrl0_wdata,
  input  logic             ctrl1_wr,
  input  logic [31:0]      ctrl1_wdata,
  input  logic [SMP_W-1:0] smp_data,
  output logic [31:0]      ctrl0_q,
  output logic [31:0]      ctrl1_q,
  output logic [31:0]      status_q,
  output logic             smp_take,
  output logic             sel_ext,
  output logic [CH_W-1:0]  sel_chan
);
  localparam int SRC_W = CH_W + 1;

  function automatic logic run_of(input logic [REG_W-1:0] c);
    return c[C0_START] && c[C0_ENABLE] && !c[C0_SRST];
  endfunction

  // effective source: {external, channel}; channel ignored when internal
  function automatic logic [SRC_W-1:0] src_of(input logic [REG_W-1:0] c);
    if (c[C0_MODE_LSB +: 2] == SRC_EXTERNAL) return {1'b1, c[C0_CHAN_LSB +: CH_W]};
    return '0;
  endfunction

  logic [REG_W-1:0] c0_q, c1_q;
  logic             run_q, run_n;
  logic             src_chg, run_chg, cfg_chg, clr, drop;
  logic             bypass;
  logic [OSR_W-1:0] osr;
  logic [EXP_W-1:0] n_eff;
  logic             tick, acc_done;
  logic [SMP_W-1:0] acc_res, res_q;
  logic             valid_q;
  logic [SRC_W-1:0] src_q;

  always_comb begin
    run_q   = run_of(c0_q);
    run_n   = run_of(ctrl0_wdata);
    src_q   = src_of(c0_q);
    bypass  = c0_q[C0_NOAVG];
    osr     = c0_q[C0_OSR_LSB +: OSR_W];
    n_eff   = bypass ? '0 : c1_q[EXP_W-1:0];
    src_chg = ctrl0_wr && (src_of(ctrl0_wdata) != src_q);
    run_chg = ctrl0_wr && (run_n != run_q);
    cfg_chg = ctrl0_wr && ((ctrl0_wdata[C0_OSR_LSB +: OSR_W] != osr) ||
                           (ctrl0_wdata[C0_NOAVG] != bypass));
    clr     = src_chg || run_chg || cfg_chg || ctrl1_wr;
    drop    = src_chg || (ctrl0_wr && !run_n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c0_q <= '0;
      c1_q <= '0;
    end else begin
      if (ctrl0_wr) c0_q <= ctrl0_wdata;
      if (ctrl1_wr) c1_q <= ctrl1_wdata;
    end
  end

  tsense_timer #(.STEP(STEP_CYCLES), .OSR_W(OSR_W)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (clr),
    .run  (run_q),
    .osr  (osr),
    .tick (tick)
  );

  tsense_accum #(.SMP_W(SMP_W), .EXP_W(EXP_W)) u_accum (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .tick  (tick),
    .smp   (smp_data),
    .n     (n_eff),
    .done  (acc_done),
    .result(acc_res)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      res_q   <= '0;
    end else if (drop) begin
      valid_q <= 1'b0;
    end else if (acc_done && !clr) begin
      valid_q <= 1'b1;
      res_q   <= acc_res;
    end
  end

  always_comb begin
    status_q                 = '0;
    status_q[SMP_W-1:0]      = res_q;
    status_q[ST_VALID]       = valid_q;
    ctrl0_q                  = c0_q;
    ctrl1_q                  = c1_q;
    smp_take                 = tick;
    sel_ext                  = src_q[CH_W];
    sel_chan                 = src_q[CH_W-1:0];
  end

  // R1: no capture while the run condition is false
  p_idle_no_take_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> !smp_take);
  // R2: front-end selection changes only through a control-0 write
  p_sel_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl0_wr |=> ($stable(sel_ext) && $stable(sel_chan)));
  // R4: the flag rises only when a window has completed
  p_valid_from_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_q) |-> $past(acc_done));
  // R6: a source switch drops the flag
  p_src_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    src_chg |=> !valid_q);
  // R7: a stopped sequencer never shows valid data
  p_stop_invalid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> !valid_q);
  // R8: a write that keeps source and run keeps the flag
  p_keep_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl0_wr && !src_chg && run_n && valid_q) |=> valid_q);
endmodule

// File: tb/tsense_seq_tb.sv
module tsense_seq_tb;
  localparam int CLK_P = 10;
  localparam int STEP  = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl0_wr = 1'b0, ctrl1_wr = 1'b0;
  logic [31:0] ctrl0_wdata = '0, ctrl1_wdata = '0;
  logic [9:0]  smp_data = '0;
  logic [31:0] ctrl0_q, ctrl1_q, status_q;
  logic        smp_take, sel_ext;
  logic [3:0]  sel_chan;

  int n_run = 0, n_fail = 0;
  int osr_b = 0;
  int pre[2];

  always #(CLK_P/2) clk = ~clk;

  tsense_seq #(.STEP_CYCLES(STEP)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .ctrl0_wr(ctrl0_wr), .ctrl0_wdata(ctrl0_wdata),
    .ctrl1_wr(ctrl1_wr), .ctrl1_wdata(ctrl1_wdata),
    .smp_data(smp_data),
    .ctrl0_q(ctrl0_q), .ctrl1_q(ctrl1_q), .status_q(status_q),
    .smp_take(smp_take), .sel_ext(sel_ext), .sel_chan(sel_chan)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int floor_div(input int s, input int d);
    int q;
    q = s / d;
    if ((s % d) != 0 && s < 0) q = q - 1;
    return q;
  endfunction

  function automatic logic [31:0] mk0(input bit st, input bit sr, input bit en, input bit byp,
                                      input int chan, input int osr, input int mode);
    logic [31:0] w;
    w = '0;
    w[0] = st; w[1] = sr; w[2] = en; w[6] = byp;
    w[16:13] = 4'(chan);
    w[25:24] = 2'(osr);
    w[31:30] = 2'(mode);
    return w;
  endfunction

  task automatic wr0(input logic [31:0] v);
    ctrl0_wr = 1'b1; ctrl0_wdata = v;
    @(negedge clk);
    ctrl0_wr = 1'b0;
  endtask

  task automatic wr1(input logic [31:0] v);
    ctrl1_wr = 1'b1; ctrl1_wdata = v;
    @(negedge clk);
    ctrl1_wr = 1'b0;
  endtask

  function automatic int res_of();
    return int'($signed(status_q[9:0]));
  endfunction

  // feed 2^n samples, check spacing, flag timing and the published mean
  task automatic run_conv(input int n, input bit chk_gap, input int vb, input bit use_pre);
    int sum = 0;
    int per = (osr_b + 1) * STEP;
    int cnt = 1 << n;
    int expv;
    for (int i = 0; i < cnt; i++) begin
      int k = 0;
      int v;
      while (!smp_take && k < 5000) begin
        @(negedge clk);
        k++;
      end
      if (k >= 5000) begin
        check(1'b0, "R3 no sample", k, per - 1);
        return;
      end
      if (chk_gap) check(k == per - 1, "R3 sample gap", k, per - 1);
      if (i == cnt - 1 && vb >= 0)
        check(int'(status_q[16]) == vb, "R6 flag before last sample", int'(status_q[16]), vb);
      v = use_pre ? pre[i] : int'($urandom_range(0, 1023)) - 512;
      smp_data = 10'(v);
      sum += v;
      @(negedge clk);
    end
    expv = floor_div(sum, cnt);
    check(status_q[16] == 1'b1, "R6 flag after window", int'(status_q[16]), 1);
    check(res_of() == expv, "R4 mean", res_of(), expv);
    check(status_q[31:17] == '0 && status_q[15:10] == '0, "R5 unused bits", int'(status_q), 0);
  endtask

  task automatic count_takes(input int cyc, input string req);
    int t = 0;
    for (int i = 0; i < cyc; i++) begin
      if (smp_take) t++;
      @(negedge clk);
    end
    check(t == 0, req, t, 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    check(1'b0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd12345));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    check(status_q == '0, "R9 status", int'(status_q), 0);
    check(ctrl0_q == '0 && ctrl1_q == '0, "R9 ctrl", int'(ctrl0_q), 0);
    count_takes(20, "R9 R1 idle takes");

    // bypass, osr 0: each sample published
    osr_b = 0;
    wr0(mk0(1, 0, 1, 1, 0, 0, 0));
    run_conv(0, 1, 0, 0);
    repeat (5) run_conv(0, 1, 1, 0);

    // R4 rounding toward minus infinity: -1,-2 -> -2
    wr0(mk0(1, 0, 1, 0, 0, 0, 0));
    wr1(32'd1);
    pre[0] = -1; pre[1] = -2;
    run_conv(1, 1, 1, 1);
    pre[0] = 3; pre[1] = 4;
    run_conv(1, 1, 1, 1);

    // R3 / R4 across rates and window sizes
    for (int o = 0; o < 4; o++) begin
      n = int'($urandom_range(0, 3));
      osr_b = o;
      wr0(mk0(1, 0, 1, 0, 0, o, 0));
      wr1(32'(n));
      run_conv(n, 1, 1, 0);
      run_conv(n, 1, 1, 0);
    end

    // R2 / R6 external source switch
    osr_b = 1;
    wr1(32'd2);
    wr0(mk0(1, 0, 1, 0, 5, 1, 2));
    check(sel_ext == 1'b1 && sel_chan == 4'd5, "R2 external sel", int'(sel_chan), 5);
    check(status_q[16] == 1'b0, "R6 drop on mode switch", int'(status_q[16]), 0);
    run_conv(2, 1, 0, 0);
    wr0(mk0(1, 0, 1, 0, 9, 1, 2));
    check(status_q[16] == 1'b0, "R6 drop on channel switch", int'(status_q[16]), 0);
    check(sel_chan == 4'd9, "R2 channel", int'(sel_chan), 9);
    run_conv(2, 1, 0, 0);
    wr0(mk0(1, 0, 1, 0, 9, 1, 3));
    check(sel_ext == 1'b0 && sel_chan == 4'd0, "R2 mode 3 internal", int'(sel_ext), 0);
    check(status_q[16] == 1'b0, "R6 drop back to internal", int'(status_q[16]), 0);
    run_conv(2, 1, 0, 0);

    // R8 channel change while internal keeps the flag
    wr0(mk0(1, 0, 1, 0, 12, 1, 3));
    check(status_q[16] == 1'b1, "R8 flag kept", int'(status_q[16]), 1);
    check(sel_chan == 4'd0, "R8 channel ignored", int'(sel_chan), 0);
    run_conv(2, 0, 1, 0);

    // R7 / R1 stop conditions
    wr0(mk0(0, 0, 1, 0, 0, 1, 0));
    check(status_q[16] == 1'b0, "R7 stop clears flag", int'(status_q[16]), 0);
    count_takes(40, "R1 start low");
    wr0(mk0(1, 0, 0, 0, 0, 1, 0));
    count_takes(40, "R1 enable low");
    wr0(mk0(1, 1, 1, 0, 0, 1, 0));
    count_takes(40, "R1 sensor reset");
    check(status_q[16] == 1'b0, "R7 flag stays low", int'(status_q[16]), 0);

    // R7 restart discards a partial window
    wr0(mk0(1, 0, 1, 0, 0, 1, 0));
    while (!smp_take) @(negedge clk);
    smp_data = 10'd500;
    @(negedge clk);
    wr0(mk0(0, 0, 1, 0, 0, 1, 0));
    wr0(mk0(1, 0, 1, 0, 0, 1, 0));
    run_conv(2, 1, 0, 0);

    // R10 readback
    begin
      logic [31:0] a, b;
      a = $urandom() & ~32'h1;
      b = $urandom();
      wr0(a);
      wr1(b);
      check(ctrl0_q == a, "R10 ctrl0 readback", int'(ctrl0_q), int'(a));
      check(ctrl1_q == b, "R10 ctrl1 readback", int'(ctrl1_q), int'(b));
    end

    // R4 widest window
    osr_b = 0;
    wr0(mk0(1, 0, 1, 0, 0, 0, 0));
    wr1(32'd7);
    run_conv(7, 1, 0, 0);

    // R4 bypass overrides exponent
    wr0(mk0(1, 0, 1, 1, 0, 0, 0));
    wr1(32'd3);
    run_conv(0, 1, 1, 0);
    run_conv(0, 1, 1, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule